// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

The engine takes received frames as a byte stream with a valid strobe and a last marker and writes them into packet buffers that a host hands over through a ring of receive descriptors. Each descriptor carries a flag byte, a buffer length stored as a negated size, and a 12-bit message length. The host gives a descriptor to the engine by writing its buffer length. That write also clears the message length and sets the ownership bit. The engine fills buffers in ring order, writes back the length and status, and returns each descriptor to the host by clearing ownership. It raises a one-cycle done pulse when a frame ends.

A frame larger than its buffer continues into the next descriptor when the engine owns that descriptor. Only the last descriptor of the frame carries the end marker, the total length and any error bits. If no engine-owned descriptor is ready when a frame begins, the whole frame is discarded and a missed-frame pulse is raised. If the next descriptor is host-owned when a buffer runs full, the frame is cut short and overflow is reported. An input flag given with the last byte marks a frame whose check sequence was bad. The stream has no backpressure.

Top module: `rxr_engine`

## Requirements
- R1: After reset every descriptor has flag byte 0x00 (host-owned), message length 0, and neither `rx_done` nor `rx_miss` is high.
- R2: A host write to a descriptor stores the given buffer-length word, sets the flag byte to 0x80 (bit 7 = engine owns) and clears the message length.
- R3: The buffer size used is the low 12 bits of the two's complement of the buffer-length word, whose top four bits are ones. A size of 0 or a size above the buffer capacity (16 bytes by default) is treated as the capacity.
- R4: A frame that fits in one buffer leaves that descriptor with flag 0x03 (bit 1 start, bit 0 end, no error bits, bit 7 clear). Its message length is the count of received bytes, frame check sequence included. Byte k is stored at buffer offset k.
- R5: A frame whose last byte has `rx_crc_err` high gets bit 6 (error summary) and bit 3 (CRC error) on its final descriptor, which gives flag 0x4B for a single-buffer frame.
- R6: A frame larger than its buffer spans engine-owned descriptors in ring order. A non-final descriptor gets flag 0x02 if it holds the start of the frame and 0x00 otherwise, with message length 0 and no error bits. The final descriptor gets bit 0, the total frame length and any error bits.
- R7: If the descriptor at the current index is host-owned when a frame's first byte arrives, `rx_miss` pulses for one cycle in the cycle after that byte. The frame is then dropped and the current index is unchanged.
- R8: If a buffer is full and another byte arrives while the next descriptor is host-owned, the current descriptor gets flag 0x54 (bits 6, 4, 2), plus 0x02 if it holds the start, with no end bit. Its message length is the number of bytes stored. The rest of the frame is dropped and the index advances. A frame that exactly fills its buffer does not overflow.
- R9: `rx_done` pulses for exactly one cycle in the cycle after the byte that completes a descriptor hand-back (the last byte, or the overflowing byte). It is never high together with `rx_miss`.
- R10: The ring has 2^c entries, where c is `ring_code` clamped to the range 1 to RING_LOG_MAX. The index wraps to 0 after the last entry, and entries beyond the ring are never touched.
- R11: The engine writes only descriptors it owns. Each such write releases the descriptor to the host in the same cycle that its length and flags are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_code | input | 3 | Ring length code (log2 of entries); change only during reset |
| rx_valid | input | 1 | Receive byte strobe |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the last byte of a frame |
| rx_crc_err | input | 1 | Frame check failed; sampled with the last byte |
| host_we | input | 1 | Hand descriptor `host_widx` to the engine |
| host_widx | input | RING_LOG_MAX | Descriptor index for the host write |
| host_buflen | input | 16 | Negated buffer size written by the host |
| host_ridx | input | RING_LOG_MAX | Descriptor index for host readback |
| host_flag | output | 8 | Flag byte of descriptor `host_ridx`, one cycle later |
| host_buflen_rd | output | 16 | Buffer-length word of descriptor `host_ridx`, one cycle later |
| host_msglen | output | 16 | Message length of descriptor `host_ridx` (upper 4 bits zero), one cycle later |
| host_baddr | input | RING_LOG_MAX+BUF_LOG | Packet buffer byte address {index, offset} |
| host_bdata | output | 8 | Packet buffer byte at `host_baddr`, one cycle later |
| rx_done | output | 1 | Descriptor hand-back pulse |
| rx_miss | output | 1 | Missed-frame pulse |

## Verification
A wrong ring index shows up at the next host readback as a status written into the wrong slot, or as a miss pulse where a done pulse belongs. Either appears within one cycle of the frame boundary, because the pulses are compared against the reference on every clock. A wrong byte offset or buffer size shows as a misplaced payload byte, a wrong message length, or an overflow flag on a frame that should have fitted. A wrong start or error bookkeeping shows in the flag byte of the spanning or overflowing descriptor as soon as the host reads it back.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam logic [7:0] M_OWN  = 8'h80;
  localparam logic [7:0] M_ERR  = 8'h40;
  localparam logic [7:0] M_OFLO = 8'h10;
  localparam logic [7:0] M_CRC  = 8'h08;
  localparam logic [7:0] M_BUFF = 8'h04;
  localparam logic [7:0] M_STP  = 8'h02;
  localparam logic [7:0] M_ENP  = 8'h01;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_DROP} rx_state_e;
endpackage

// File: rtl/rxr_desc_ring.sv
module rxr_desc_ring #(
  parameter int IDXW    = 3,
  parameter int ENTRIES = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            h_we,
  input  logic [IDXW-1:0] h_widx,
  input  logic [15:0]     h_buflen,
  input  logic            w0_en,
  input  logic [IDXW-1:0] w0_idx,
  input  logic [7:0]      w0_flag,
  input  logic [11:0]     w0_len,
  input  logic            w1_en,
  input  logic [IDXW-1:0] w1_idx,
  input  logic [7:0]      w1_flag,
  input  logic [11:0]     w1_len,
  input  logic [IDXW-1:0] a_idx,
  output logic            a_own,
  output logic [11:0]     a_buflen,
  input  logic [IDXW-1:0] b_idx,
  output logic            b_own,
  output logic [11:0]     b_buflen,
  input  logic [IDXW-1:0] h_ridx,
  output logic [7:0]      h_flag,
  output logic [15:0]     h_buflen_rd,
  output logic [15:0]     h_msglen
);
  import rxr_pkg::*;

  logic [7:0]  flag_q [ENTRIES];
  logic [15:0] bl_q   [ENTRIES];
  logic [11:0] len_q  [ENTRIES];

  assign a_own    = flag_q[a_idx][7];
  assign a_buflen = bl_q[a_idx][11:0];
  assign b_own    = flag_q[b_idx][7];
  assign b_buflen = bl_q[b_idx][11:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        flag_q[i] <= 8'h00;
        bl_q[i]   <= 16'h0000;
        len_q[i]  <= 12'h000;
      end
      h_flag      <= 8'h00;
      h_buflen_rd <= 16'h0000;
      h_msglen    <= 16'h0000;
    end else begin
      if (h_we) begin
        flag_q[h_widx] <= M_OWN;
        bl_q[h_widx]   <= h_buflen;
        len_q[h_widx]  <= 12'h000;
      end
      if (w0_en) begin
        flag_q[w0_idx] <= w0_flag;
        len_q[w0_idx]  <= w0_len;
      end
      if (w1_en) begin
        flag_q[w1_idx] <= w1_flag;
        len_q[w1_idx]  <= w1_len;
      end
      h_flag      <= flag_q[h_ridx];
      h_buflen_rd <= bl_q[h_ridx];
      h_msglen    <= {4'h0, len_q[h_ridx]};
    end
  end

  // R11: the engine only rewrites descriptors it currently owns
  p_eng_write_owned_r11: assert property (@(posedge clk) disable iff (rst)
    w0_en |-> flag_q[w0_idx][7]);
  p_eng_write1_owned_r11: assert property (@(posedge clk) disable iff (rst)
    w1_en |-> flag_q[w1_idx][7]);
  // R11: after an engine write the descriptor belongs to the host
  p_released_r11: assert property (@(posedge clk) disable iff (rst)
    (w0_en && !h_we) |=> !flag_q[$past(w0_idx)][7]);
endmodule

// File: rtl/rxr_buf_mem.sv
module rxr_buf_mem #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl #(
  parameter int RING_LOG_MAX = 3,
  parameter int BUF_LOG      = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [2:0]              ring_code,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_data,
  input  logic                    rx_last,
  input  logic                    rx_crc_err,
  input  logic                    cur_own,
  input  logic [11:0]             cur_buflen,
  input  logic                    nxt_own,
  input  logic [11:0]             nxt_buflen,
  output logic [RING_LOG_MAX-1:0] cur_idx,
  output logic [RING_LOG_MAX-1:0] nxt_idx,
  output logic                    w0_en,
  output logic [RING_LOG_MAX-1:0] w0_idx,
  output logic [7:0]              w0_flag,
  output logic [11:0]             w0_len,
  output logic                    w1_en,
  output logic [RING_LOG_MAX-1:0] w1_idx,
  output logic [7:0]              w1_flag,
  output logic [11:0]             w1_len,
  output logic                    mem_we,
  output logic [RING_LOG_MAX+BUF_LOG-1:0] mem_waddr,
  output logic [7:0]              mem_wdata,
  output logic                    rx_done,
  output logic                    rx_miss
);
  import rxr_pkg::*;

  localparam int IDXW = RING_LOG_MAX;
  localparam int OFFW = BUF_LOG + 1;
  localparam int MAXB = 1 << BUF_LOG;

  function automatic logic [OFFW-1:0] buf_size(input logic [11:0] bl);
    logic [11:0] n;
    n = ~bl + 12'd1;
    if (n == 12'd0 || n > 12'(MAXB)) return OFFW'(MAXB);
    return n[OFFW-1:0];
  endfunction

  function automatic logic [7:0] fin_flag(input logic first, input logic crc);
    return M_ENP | (first ? M_STP : 8'h00) | (crc ? (M_ERR | M_CRC) : 8'h00);
  endfunction

  rx_state_e        st_q;
  logic [IDXW-1:0]  cur_q, mask, nxt2;
  logic [OFFW-1:0]  off_q, bsz_q;
  logic [11:0]      cnt_q;
  logic             first_q, full;
  logic [2:0]       lg;
  logic [IDXW-1:0]  mem_idx;
  logic [BUF_LOG-1:0] mem_off;

  always_comb begin
    lg = ring_code;
    if (lg == 3'd0) lg = 3'd1;
    if (int'(lg) > RING_LOG_MAX) lg = 3'(RING_LOG_MAX);
    mask = IDXW'((32'd1 << lg) - 32'd1);
  end

  assign cur_idx   = cur_q;
  assign nxt_idx   = (cur_q + IDXW'(1)) & mask;
  assign nxt2      = (nxt_idx + IDXW'(1)) & mask;
  assign full      = (off_q == bsz_q);
  assign mem_waddr = {mem_idx, mem_off};
  assign mem_wdata = rx_data;

  always_comb begin
    mem_we  = 1'b0;  mem_idx = cur_q;  mem_off = off_q[BUF_LOG-1:0];
    w0_en   = 1'b0;  w0_idx  = cur_q;  w0_flag = 8'h00; w0_len = 12'h000;
    w1_en   = 1'b0;  w1_idx  = nxt_idx; w1_flag = 8'h00; w1_len = 12'h000;
    unique case (st_q)
      ST_IDLE: if (rx_valid && cur_own) begin
        mem_we  = 1'b1;
        mem_off = '0;
        if (rx_last) begin
          w0_en = 1'b1; w0_flag = fin_flag(1'b1, rx_crc_err); w0_len = 12'd1;
        end
      end
      ST_FILL: if (rx_valid) begin
        if (full && nxt_own) begin
          w0_en   = 1'b1; w0_flag = first_q ? M_STP : 8'h00;
          mem_we  = 1'b1; mem_idx = nxt_idx; mem_off = '0;
          if (rx_last) begin
            w1_en = 1'b1; w1_flag = fin_flag(1'b0, rx_crc_err); w1_len = cnt_q + 12'd1;
          end
        end else if (full) begin
          w0_en   = 1'b1;
          w0_flag = M_ERR | M_OFLO | M_BUFF | (first_q ? M_STP : 8'h00);
          w0_len  = cnt_q;
        end else begin
          mem_we = 1'b1;
          if (rx_last) begin
            w0_en = 1'b1; w0_flag = fin_flag(first_q, rx_crc_err); w0_len = cnt_q + 12'd1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE; cur_q <= '0; off_q <= '0; bsz_q <= '0;
      cnt_q <= '0; first_q <= 1'b0; rx_done <= 1'b0; rx_miss <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      rx_miss <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (rx_valid) begin
          if (cur_own) begin
            off_q <= OFFW'(1); cnt_q <= 12'd1; first_q <= 1'b1;
            bsz_q <= buf_size(cur_buflen);
            if (rx_last) begin rx_done <= 1'b1; cur_q <= nxt_idx; end
            else st_q <= ST_FILL;
          end else begin
            rx_miss <= 1'b1;
            if (!rx_last) st_q <= ST_DROP;
          end
        end
        ST_FILL: if (rx_valid) begin
          if (full && nxt_own) begin
            off_q <= OFFW'(1); cnt_q <= cnt_q + 12'd1; first_q <= 1'b0;
            bsz_q <= buf_size(nxt_buflen);
            if (rx_last) begin rx_done <= 1'b1; cur_q <= nxt2; st_q <= ST_IDLE; end
            else cur_q <= nxt_idx;
          end else if (full) begin
            rx_done <= 1'b1; cur_q <= nxt_idx;
            st_q <= rx_last ? ST_IDLE : ST_DROP;
          end else begin
            off_q <= off_q + OFFW'(1); cnt_q <= cnt_q + 12'd1;
            if (rx_last) begin rx_done <= 1'b1; cur_q <= nxt_idx; st_q <= ST_IDLE; end
          end
        end
        ST_DROP: if (rx_valid && rx_last) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R8: the fill offset never passes the active buffer size
  p_off_in_buf_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FILL) |-> (off_q <= bsz_q));
  // R7: a missed frame leaves the ring index where it was
  p_miss_keeps_idx_r7: assert property (@(posedge clk) disable iff (rst)
    rx_miss |-> $stable(cur_q));
  // R9: done and miss are never raised together
  p_done_excl_miss_r9: assert property (@(posedge clk) disable iff (rst)
    !(rx_done && rx_miss));
  // R10: the index stays inside the configured ring
  p_idx_in_ring_r10: assert property (@(posedge clk) disable iff (rst)
    (cur_q & ~mask) == '0);
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine #(
  parameter int RING_LOG_MAX = 3,
  parameter int BUF_LOG      = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [2:0]                      ring_code,
  input  logic                            rx_valid,
  input  logic [7:0]                      rx_data,
  input  logic                            rx_last,
  input  logic                            rx_crc_err,
  input  logic                            host_we,
  input  logic [RING_LOG_MAX-1:0]         host_widx,
  input  logic [15:0]                     host_buflen,
  input  logic [RING_LOG_MAX-1:0]         host_ridx,
  output logic [7:0]                      host_flag,
  output logic [15:0]                     host_buflen_rd,
  output logic [15:0]                     host_msglen,
  input  logic [RING_LOG_MAX+BUF_LOG-1:0] host_baddr,
  output logic [7:0]                      host_bdata,
  output logic                            rx_done,
  output logic                            rx_miss
);
  localparam int IDXW    = RING_LOG_MAX;
  localparam int ENTRIES = 1 << RING_LOG_MAX;
  localparam int AW      = RING_LOG_MAX + BUF_LOG;

  logic            cur_own, nxt_own, w0_en, w1_en, mem_we;
  logic [11:0]     cur_bl, nxt_bl, w0_len, w1_len;
  logic [IDXW-1:0] cur_idx, nxt_idx, w0_idx, w1_idx;
  logic [7:0]      w0_flag, w1_flag, mem_wdata;
  logic [AW-1:0]   mem_waddr;

  rxr_ctrl #(.RING_LOG_MAX(RING_LOG_MAX), .BUF_LOG(BUF_LOG)) u_ctrl (
    .clk(clk), .rst(rst), .ring_code(ring_code),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_crc_err(rx_crc_err),
    .cur_own(cur_own), .cur_buflen(cur_bl), .nxt_own(nxt_own), .nxt_buflen(nxt_bl),
    .cur_idx(cur_idx), .nxt_idx(nxt_idx),
    .w0_en(w0_en), .w0_idx(w0_idx), .w0_flag(w0_flag), .w0_len(w0_len),
    .w1_en(w1_en), .w1_idx(w1_idx), .w1_flag(w1_flag), .w1_len(w1_len),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .rx_done(rx_done), .rx_miss(rx_miss));

  rxr_desc_ring #(.IDXW(IDXW), .ENTRIES(ENTRIES)) u_ring (
    .clk(clk), .rst(rst),
    .h_we(host_we), .h_widx(host_widx), .h_buflen(host_buflen),
    .w0_en(w0_en), .w0_idx(w0_idx), .w0_flag(w0_flag), .w0_len(w0_len),
    .w1_en(w1_en), .w1_idx(w1_idx), .w1_flag(w1_flag), .w1_len(w1_len),
    .a_idx(cur_idx), .a_own(cur_own), .a_buflen(cur_bl),
    .b_idx(nxt_idx), .b_own(nxt_own), .b_buflen(nxt_bl),
    .h_ridx(host_ridx), .h_flag(host_flag), .h_buflen_rd(host_buflen_rd),
    .h_msglen(host_msglen));

  rxr_buf_mem #(.AW(AW)) u_buf (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(host_baddr), .rdata(host_bdata));
endmodule

// File: tb/rxr_engine_tb_top.sv
module rxr_engine_tb_top;
  localparam int NENT = 8;
  localparam int MAXB = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] ring_code = 3'd2;
  logic rx_valid = 0, rx_last = 0, rx_crc_err = 0;
  logic [7:0] rx_data = 8'h00;
  logic host_we = 0;
  logic [2:0] host_widx = 0, host_ridx = 0;
  logic [15:0] host_buflen = 0;
  logic [6:0] host_baddr = 0;
  logic [7:0] host_flag, host_bdata;
  logic [15:0] host_buflen_rd, host_msglen;
  logic rx_done, rx_miss;

  always #5 clk = ~clk;

  rxr_engine dut_i (
    .clk(clk), .rst(rst), .ring_code(ring_code),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_crc_err(rx_crc_err),
    .host_we(host_we), .host_widx(host_widx), .host_buflen(host_buflen),
    .host_ridx(host_ridx), .host_flag(host_flag), .host_buflen_rd(host_buflen_rd),
    .host_msglen(host_msglen), .host_baddr(host_baddr), .host_bdata(host_bdata),
    .rx_done(rx_done), .rx_miss(rx_miss));

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  bit pend_done = 0, pend_miss = 0;
  int m_flag [NENT];
  int m_len  [NENT];
  int m_bl   [NENT];
  int m_mem  [NENT*MAXB];
  int m_cur = 0, m_mask = 3;

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // every clock: pulses compared against the reference
  task automatic tick();
    @(negedge clk);
    if (!rst) begin
      chk("R9 rx_done", int'(rx_done), int'(pend_done));
      chk("R7 rx_miss", int'(rx_miss), int'(pend_miss));
    end
    pend_done = 0;
    pend_miss = 0;
  endtask

  function automatic int dsz(int bl);
    int n;
    n = ((~bl) + 1) & 12'hFFF;
    if (n == 0 || n > MAXB) return MAXB;
    return n;
  endfunction

  function automatic int pat(int seed, int i);
    return (seed + i * 7) & 255;
  endfunction

  task automatic model_reset(int code);
    int c;
    for (int i = 0; i < NENT; i++) begin m_flag[i] = 0; m_len[i] = 0; m_bl[i] = 0; end
    c = (code < 1) ? 1 : (code > 3 ? 3 : code);
    m_mask = (1 << c) - 1;
    m_cur = 0;
  endtask

  task automatic model_frame(int len, int crc, int seed, output int done_at, output int miss);
    int off, first, sz, nx;
    done_at = -1; miss = 0; off = 0; first = 1;
    if ((m_flag[m_cur] & 128) == 0) begin miss = 1; return; end
    sz = dsz(m_bl[m_cur]);
    for (int i = 0; i < len; i++) begin
      if (off == sz) begin
        nx = (m_cur + 1) & m_mask;
        if ((m_flag[nx] & 128) != 0) begin
          m_flag[m_cur] = first ? 2 : 0; m_len[m_cur] = 0;
          m_cur = nx; first = 0; off = 0; sz = dsz(m_bl[m_cur]);
        end else begin
          m_flag[m_cur] = 'h54 | (first ? 2 : 0); m_len[m_cur] = i;
          m_cur = nx; done_at = i;
          return;
        end
      end
      m_mem[m_cur*MAXB + off] = pat(seed, i);
      off++;
    end
    m_flag[m_cur] = 1 | (first ? 2 : 0) | (crc ? 'h48 : 0);
    m_len[m_cur] = len;
    m_cur = (m_cur + 1) & m_mask;
    done_at = len - 1;
  endtask

  task automatic give(int idx, int bl);
    host_we = 1; host_widx = idx[2:0]; host_buflen = bl[15:0];
    m_flag[idx] = 'h80; m_bl[idx] = bl; m_len[idx] = 0;
    tick();
    host_we = 0;
  endtask

  task automatic send(int len, int crc, int seed);
    int done_at, miss;
    model_frame(len, crc, seed, done_at, miss);
    for (int i = 0; i < len; i++) begin
      rx_valid = 1; rx_data = pat(seed, i); rx_last = (i == len - 1);
      rx_crc_err = (i == len - 1) ? crc[0] : 1'b0;
      pend_done = (i == done_at);
      pend_miss = (i == 0) && (miss != 0);
      tick();
    end
    rx_valid = 0; rx_last = 0; rx_crc_err = 0;
    tick();
  endtask

  task automatic rd_desc(int idx, string req);
    host_ridx = idx[2:0];
    tick();
    chk({req, " flag"}, int'(host_flag), m_flag[idx]);
    chk({req, " msglen"}, int'(host_msglen), m_len[idx]);
    chk({req, " buflen"}, int'(host_buflen_rd), m_bl[idx]);
  endtask

  task automatic rd_byte(int addr, string req);
    host_baddr = addr[6:0];
    tick();
    chk(req, int'(host_bdata), m_mem[addr]);
  endtask

  initial begin
    model_reset(2);
    repeat (3) tick();
    rst = 0;
    tick();
    // R1: reset state
    rd_desc(0, "R1 d0");
    rd_desc(3, "R1 d3");
    // R2: host hand-over
    for (int i = 0; i < 4; i++) give(i, 'hFFF0);
    rd_desc(0, "R2 d0");
    // R4: single-buffer frame
    send(10, 0, 17);
    rd_desc(0, "R4 d0");
    chk("R4 flag literal", int'(host_flag), 'h03);
    rd_byte(0, "R4 byte0");
    rd_byte(9, "R4 byte9");
    // R5: CRC error frame
    send(8, 1, 40);
    rd_desc(1, "R5 d1");
    chk("R5 flag literal", int'(host_flag), 'h4B);
    // R6: spanning frame, error on last only
    send(20, 1, 90);
    rd_desc(2, "R6 d2");
    chk("R6 first flag literal", int'(host_flag), 'h02);
    rd_desc(3, "R6 d3");
    chk("R6 last flag literal", int'(host_flag), 'h49);
    rd_byte(3*MAXB + 3, "R6 byte19");
    rd_byte(2*MAXB + 15, "R6 byte15");
    // R7 / R11: wrapped to host-owned d0, frame missed, d0 untouched
    send(5, 0, 3);
    rd_desc(0, "R11 d0 unchanged");
    // R3 + R8: 8-byte buffer, next host-owned, 12-byte frame overflows
    give(0, 'hFFF8);
    send(12, 0, 55);
    rd_desc(0, "R8 overflow d0");
    chk("R8 flag literal", int'(host_flag), 'h56);
    rd_byte(7, "R3 byte7");
    // R8 boundary: exact fit with next host-owned
    give(1, 'hFFF8);
    send(8, 0, 77);
    rd_desc(1, "R8 exact fit d1");
    // R3: size 0 decodes to capacity
    give(2, 'hF000);
    send(16, 0, 11);
    rd_desc(2, "R3 zero size d2");
    rd_byte(2*MAXB + 15, "R3 byte15");
    // R10: two-entry ring
    rst = 1; ring_code = 3'd1; model_reset(1);
    repeat (2) tick();
    rst = 0;
    tick();
    give(0, 'hFFF0); give(1, 'hFFF0); give(2, 'hFFF0);
    send(3, 0, 5);
    send(3, 0, 6);
    give(0, 'hFFF0);
    send(4, 0, 7);
    rd_desc(0, "R10 wrap d0");
    rd_desc(1, "R10 d1");
    rd_desc(2, "R10 outside ring d2");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule